// File: doc/BRIEF.md
# Segmented Address Translator and Normalizer

This unit turns a real-mode segment:offset pair into a 20-bit physical byte address. The segment is weighted by sixteen, meaning it is shifted left four bits, and then added to the offset. Any carry out of the top address bit is dropped, and a flag reports that it happened.

The same unit also gives the canonical normalized form of pair A. In that form the offset lies in 0h..Fh and the segment holds the remaining upper address bits.

A second pair, B, is translated in parallel. An alias output goes high when both pairs land on the same physical byte. Many different pairs can name the same location, and only their normalized forms are unique, so this check lets a consumer detect such aliases cheaply.

All results are registered. They appear one clock after the inputs are sampled.

Top module: `seg_alias_xlat`

## Requirements
- R1: One clock after the inputs are sampled, `a_phys` equals (a_seg × 16 + a_off) modulo 2^20.
- R2: Translating 1000h:1F00h yields 11F00h.
- R3: `a_wrap` is 1 exactly when a_seg × 16 + a_off is 2^20 or more, and `b_wrap` follows the same rule for pair B. For example, FFFFh:0010h gives address 00000h with the flag set, and FFFFh:000Fh gives FFFFFh with the flag clear.
- R4: `norm_seg` equals bits 19:4 of pair A's physical address, and `norm_off` equals bits 3:0, so 1000h:1F00h normalizes to 11F0h:0h.
- R5: `alias_hit` is 1 exactly when the modulo-2^20 physical addresses of pair A and pair B are equal. For example, 1000h:1F00h, 11F0h:0000h, 1100h:0F00h and 1080h:1700h all alias one another.
- R6: Two pairs whose offsets are both in 0h..Fh alias only when they are identical. For example, 11F0h:0h against 11F0h:1h or 11F1h:0h reports no alias.
- R7: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_seg | input | 16 | Segment of pair A |
| a_off | input | 16 | Offset of pair A |
| b_seg | input | 16 | Segment of pair B |
| b_off | input | 16 | Offset of pair B |
| a_phys | output | 20 | Physical address of pair A |
| a_wrap | output | 1 | Pair A's sum carried past bit 19 |
| b_wrap | output | 1 | Pair B's sum carried past bit 19 |
| norm_seg | output | 16 | Normalized segment of pair A |
| norm_off | output | 4 | Normalized offset of pair A |
| alias_hit | output | 1 | Pairs A and B address the same byte |

## Verification
On every cycle, the embedded properties check several relations:
- The registered address against the previous cycle's inputs.
- That a wrapped result always lies below its own offset.
- That the normalized pair reassembles into the physical address.
- The cleared outputs after reset.

Only the bench's scenarios can show the concrete examples. These are the published alias set, the exact wrap boundary at FFFFh:000Fh versus FFFFh:0010h, and the rejection of near-miss normalized pairs. The bench also checks, over random traffic, that alias reports agree with an independent model.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
    localparam int SEG_BITS   = 16;
    localparam int OFF_BITS   = 16;
    localparam int PARA_SHIFT = 4;
    localparam int PHYS_BITS  = SEG_BITS + PARA_SHIFT;
endpackage

// File: rtl/seg_phys_adder.sv
module seg_phys_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys,
    output logic              carry
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = {1'b0, seg, {SHIFT{1'b0}}} + {{(SUM_W-OFF_W){1'b0}}, off};
        phys  = sum[ADDR_W-1:0];
        carry = sum[ADDR_W];
    end
endmodule

// File: rtl/seg_norm_split.sv
module seg_norm_split #(
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0]       phys,
    output logic [ADDR_W-SHIFT-1:0] nseg,
    output logic [SHIFT-1:0]        noff
);
    assign nseg = phys[ADDR_W-1:SHIFT];
    assign noff = phys[SHIFT-1:0];
endmodule

// File: rtl/seg_alias_xlat.sv
module seg_alias_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W  = SEG_BITS,
    parameter int OFF_W  = OFF_BITS,
    parameter int SHIFT  = PARA_SHIFT,
    parameter int ADDR_W = SEG_W + SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEG_W-1:0]        a_seg,
    input  logic [OFF_W-1:0]        a_off,
    input  logic [SEG_W-1:0]        b_seg,
    input  logic [OFF_W-1:0]        b_off,
    output logic [ADDR_W-1:0]       a_phys,
    output logic                    a_wrap,
    output logic                    b_wrap,
    output logic [ADDR_W-SHIFT-1:0] norm_seg,
    output logic [SHIFT-1:0]        norm_off,
    output logic                    alias_hit
);
    localparam int NPAIR = 2;
    localparam int NSEG_W = ADDR_W - SHIFT;

    typedef struct packed {
        logic [ADDR_W-1:0] phys;
        logic              wrap_a;
        logic              wrap_b;
        logic [NSEG_W-1:0] nseg;
        logic [SHIFT-1:0]  noff;
        logic              hit;
    } xlat_st_t;

    logic [SEG_W-1:0]  pair_seg  [NPAIR];
    logic [OFF_W-1:0]  pair_off  [NPAIR];
    logic [ADDR_W-1:0] pair_phys [NPAIR];
    logic              pair_cy   [NPAIR];
    logic [NSEG_W-1:0] nseg_c;
    logic [SHIFT-1:0]  noff_c;

    xlat_st_t st_d, st_q;
    logic     primed_q;

    assign pair_seg[0] = a_seg;
    assign pair_off[0] = a_off;
    assign pair_seg[1] = b_seg;
    assign pair_off[1] = b_off;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        seg_phys_adder #(
            .SEG_W (SEG_W),
            .OFF_W (OFF_W),
            .SHIFT (SHIFT),
            .ADDR_W(ADDR_W)
        ) add_i (
            .seg  (pair_seg[g]),
            .off  (pair_off[g]),
            .phys (pair_phys[g]),
            .carry(pair_cy[g])
        );
    end

    seg_norm_split #(
        .SHIFT (SHIFT),
        .ADDR_W(ADDR_W)
    ) norm_i (
        .phys(pair_phys[0]),
        .nseg(nseg_c),
        .noff(noff_c)
    );

    always_comb begin
        st_d        = st_q;
        st_d.phys   = pair_phys[0];
        st_d.wrap_a = pair_cy[0];
        st_d.wrap_b = pair_cy[1];
        st_d.nseg   = nseg_c;
        st_d.noff   = noff_c;
        st_d.hit    = (pair_phys[0] == pair_phys[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            primed_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            primed_q <= 1'b1;
        end
    end

    assign a_phys    = st_q.phys;
    assign a_wrap    = st_q.wrap_a;
    assign b_wrap    = st_q.wrap_b;
    assign norm_seg  = st_q.nseg;
    assign norm_off  = st_q.noff;
    assign alias_hit = st_q.hit;

    // R1
    phys_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> a_phys == ADDR_W'(({4'b0, $past(a_seg)} << SHIFT) + {4'b0, $past(a_off)}));

    // R3
    wrap_below_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && a_wrap) |-> ({4'b0, a_phys} < {8'b0, $past(a_off)}));

    // R4
    norm_rejoin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {norm_seg, norm_off} == a_phys);

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (a_phys == '0 && !a_wrap && !b_wrap && !alias_hit && norm_seg == '0 && norm_off == '0));

    // R5
    alias_same_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(a_seg) == $past(b_seg) && $past(a_off) == $past(b_off)) |-> alias_hit);
endmodule

// File: tb/seg_alias_xlat_tb_top.sv
`timescale 1ns/1ps
module seg_alias_xlat_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_seg = '0, a_off = '0, b_seg = '0, b_off = '0;
    logic [19:0] a_phys;
    logic        a_wrap, b_wrap, alias_hit;
    logic [15:0] norm_seg;
    logic [3:0]  norm_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    seg_alias_xlat dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_seg(a_seg), .a_off(a_off), .b_seg(b_seg), .b_off(b_off),
        .a_phys(a_phys), .a_wrap(a_wrap), .b_wrap(b_wrap),
        .norm_seg(norm_seg), .norm_off(norm_off), .alias_hit(alias_hit)
    );

    function automatic logic [20:0] full_sum(input logic [15:0] s, input logic [15:0] o);
        return {1'b0, s, 4'h0} + {5'h0, o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] as, input logic [15:0] ao,
                         input logic [15:0] bs, input logic [15:0] bo);
        logic [20:0] sa, sb;
        @(negedge clk);
        a_seg = as; a_off = ao; b_seg = bs; b_off = bo;
        @(posedge clk);
        #1;
        sa = full_sum(as, ao);
        sb = full_sum(bs, bo);
        chk("R1 phys", {12'h0, a_phys}, {12'h0, sa[19:0]});
        chk("R3 a_wrap", {31'h0, a_wrap}, {31'h0, sa[20]});
        chk("R3 b_wrap", {31'h0, b_wrap}, {31'h0, sb[20]});
        chk("R4 norm_seg", {16'h0, norm_seg}, {16'h0, sa[19:4]});
        chk("R4 norm_off", {28'h0, norm_off}, {28'h0, sa[3:0]});
        chk("R5 alias", {31'h0, alias_hit}, {31'h0, (sa[19:0] == sb[19:0])});
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC0_0A11));
        a_seg = 16'h1234; a_off = 16'hFFFF; b_seg = 16'h1234; b_off = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset phys", {12'h0, a_phys}, 32'h0);
        chk("R7 reset flags", {29'h0, a_wrap, b_wrap, alias_hit}, 32'h0);
        chk("R7 reset norm", {12'h0, norm_seg, norm_off}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        apply(16'h1000, 16'h1F00, 16'h11F0, 16'h0000);
        chk("R2 phys 11F00", {12'h0, a_phys}, 32'h11F00);
        chk("R4 normalized 11F0:0", {12'h0, norm_seg, norm_off}, 32'h11F00);
        chk("R5 alias 11F0:0000", {31'h0, alias_hit}, 32'h1);
        apply(16'h1000, 16'h1F00, 16'h1100, 16'h0F00);
        chk("R5 alias 1100:0F00", {31'h0, alias_hit}, 32'h1);
        apply(16'h1000, 16'h1F00, 16'h1080, 16'h1700);
        chk("R5 alias 1080:1700", {31'h0, alias_hit}, 32'h1);
        apply(16'hFFFF, 16'h0010, 16'hFFFF, 16'h000F);
        chk("R3 wrap at 2^20", {11'h0, a_wrap, a_phys}, 32'h100000);
        chk("R3 no wrap below 2^20", {31'h0, b_wrap}, 32'h0);
        apply(16'hFFFF, 16'hFFFF, 16'h0000, 16'hFFEF);
        chk("R5 alias across wrap", {31'h0, alias_hit}, 32'h1);
        apply(16'h11F0, 16'h0000, 16'h11F0, 16'h0001);
        chk("R6 offset differs", {31'h0, alias_hit}, 32'h0);
        apply(16'h11F0, 16'h0000, 16'h11F1, 16'h0000);
        chk("R6 segment differs", {31'h0, alias_hit}, 32'h0);
        apply(16'h11F0, 16'h0007, 16'h11F0, 16'h0007);
        chk("R6 identical pair", {31'h0, alias_hit}, 32'h1);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] s0, o0, s1, o1;
            logic [3:0]  k;
            s0 = 16'($urandom);
            o0 = 16'($urandom);
            k  = 4'($urandom);
            if (i % 2 == 0) begin
                s1 = s0 + {12'h0, k};
                o1 = o0 - {8'h0, k, 4'h0};
            end else begin
                s1 = 16'($urandom);
                o1 = 16'($urandom);
            end
            apply(s0, o0, s1, o1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule